// File: doc/BRIEF.md
# Byte-Wide Microinstruction Sequencer

This block steps through a writable microcode store and turns each 8-bit microinstruction into control strobes for an 8-bit ALU and a file of four 20-bit address registers. Its output strobes carry a register select, a 4-bit displacement and an ALU function code. They also mark the cycle as a memory load, a memory store, an add, or a write to the low or page part of an address register.

The micro-program counter can be loaded directly from a byte on the memory data bus. Each opcode byte fetched from program memory therefore starts its own microroutine. A 16-bit machine instruction runs as two separate dispatches. The routine for the first opcode byte does its own work and then fetches the second byte from PC+1 into the micro-PC, which hands control to the routine for the second half.

The store is filled through a load port, and no file is read to initialise it. Microinstructions in the I/O group do nothing except advance the micro-PC.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst` is high, `upc` is 0, every strobe is 0 and `aluFunc` is the default ADD code 0. After `rst` falls, execution starts at microcode address 0.
- R2: While `loadEn` is high, a rising edge writes `loadData` into microcode address `loadAddr`. A microinstruction that neither fetches nor jumps advances `upc` by one, and address 255 wraps to 0.
- R3: Byte 00AADDDD, unless AA is 00 with D3 set, raises `accLoadEn` with `regSel`=AA and `displ`=DDDD. For AA=00 with D3 clear, this is an ordinary operand load relative to PC.
- R4: Byte 01AADDDD raises `accStoreEn` with `regSel`=AA and `displ`=DDDD.
- R5: Byte 10AADDDD raises `aluAddEn` with `regSel`=AA and `displ`=DDDD. With no pending selection, `aluFunc` is 0 (ADD).
- R6: Byte 1100FFFF raises no strobe and makes `aluFunc` equal FFFF until the next add-to-accumulator microinstruction has executed. After that, `aluFunc` returns to 0. A later 1100 byte replaces an earlier pending one.
- R7: Byte 1101AA00 raises `addrLowWe`, and byte 1101AA01 raises `addrPageWe`. Both drive `regSel`=AA and `displ`=0.
- R8: Byte 1101AA10 raises `addrLowWe` only when `condFlag` is 1. Byte 1101AA11 raises it only when `condFlag` is 0. Both drive `regSel`=AA.
- R9: Byte 00001DDD is an opcode fetch. It raises `fetchEn` with `regSel`=0 (PC) and `displ`=0DDD, and it does not raise `accLoadEn`. At the next edge, `upc` takes the value of `dataIn`.
- R10: Byte 1111FFFF is a jump. The next `upc` keeps its upper four bits and takes FFFF as its lower four bits.
- R11: Byte 1110xxxx raises no strobe, leaves `regSel` and `displ` at 0, and advances `upc` by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Write enable for the microcode store |
| loadAddr | input | 8 | Microcode address to write |
| loadData | input | 8 | Microinstruction to write |
| dataIn | input | 8 | Memory data bus byte, used by fetches |
| condFlag | input | 1 | Condition for conditional transfers |
| upc | output | 8 | Current micro-program counter |
| regSel | output | 2 | Address register select |
| displ | output | 4 | Word displacement |
| aluFunc | output | 4 | ALU function code (0 = ADD) |
| accLoadEn | output | 1 | Load accumulator byte from memory |
| accStoreEn | output | 1 | Store accumulator byte to memory |
| aluAddEn | output | 1 | Combine memory byte into accumulator |
| addrLowWe | output | 1 | Write accumulator into bits 0-15 of selected register |
| addrPageWe | output | 1 | Write bits 16-19 of selected register |
| fetchEn | output | 1 | Opcode fetch into the micro-PC |

## Verification
The bench targets the boundary between fetch and plain load from PC. If that split were decoded wrongly, operand loads would redirect the micro-PC, or fetches would also raise `accLoadEn`.

Two transfers are checked for nibble handling. A jump is taken from a non-zero upper nibble, so a design that zeroed those bits would land in the wrong page. A fetched value of 0xFE runs on through 0xFF to 0, so a wrong wrap is also exposed.

Several checks follow the pending function. It must persist across a load, apply to exactly one add and then revert, and a second pending selection must replace the first. Both conditional transfers are run under each value of the condition, which catches a swapped polarity.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int REG_W  = 2;
  localparam int DISP_W = 4;
  localparam int FUNC_W = 4;
  localparam logic [REG_W-1:0]  PC_SEL       = 2'b00;
  localparam logic [FUNC_W-1:0] FUNC_DEFAULT = 4'h0;

  typedef enum logic [1:0] {
    GRP_LOAD  = 2'b00,
    GRP_STORE = 2'b01,
    GRP_ADD   = 2'b10,
    GRP_MISC  = 2'b11
  } grp_e;

  typedef enum logic [1:0] {
    SUB_FUNC = 2'b00,
    SUB_AREG = 2'b01,
    SUB_IO   = 2'b10,
    SUB_JUMP = 2'b11
  } sub_e;

  typedef struct packed {
    logic              accLoad;
    logic              accStore;
    logic              aluAdd;
    logic              addrLow;
    logic              addrPage;
    logic              fetch;
    logic              funcSet;
    logic              jump;
    logic [REG_W-1:0]  regSel;
    logic [DISP_W-1:0] displ;
    logic [3:0]        field;
  } strobe_t;
endpackage

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic       hold,
  input  logic [7:0] instr,
  input  logic       condFlag,
  output strobe_t    strb
);
  grp_e grp;
  sub_e sub;

  assign grp = grp_e'(instr[7:6]);
  assign sub = sub_e'(instr[5:4]);

  always_comb begin
    strb = '0;
    if (!hold) begin
      unique case (grp)
        GRP_LOAD: begin
          strb.regSel = instr[5:4];
          if (instr[5:4] == PC_SEL && instr[3]) begin
            strb.fetch = 1'b1;
            strb.displ = {1'b0, instr[2:0]};
          end else begin
            strb.accLoad = 1'b1;
            strb.displ   = instr[3:0];
          end
        end
        GRP_STORE: begin
          strb.accStore = 1'b1;
          strb.regSel   = instr[5:4];
          strb.displ    = instr[3:0];
        end
        GRP_ADD: begin
          strb.aluAdd = 1'b1;
          strb.regSel = instr[5:4];
          strb.displ  = instr[3:0];
        end
        default: begin
          unique case (sub)
            SUB_FUNC: begin
              strb.funcSet = 1'b1;
              strb.field   = instr[3:0];
            end
            SUB_AREG: begin
              strb.regSel = instr[3:2];
              unique case (instr[1:0])
                2'b00:   strb.addrLow  = 1'b1;
                2'b01:   strb.addrPage = 1'b1;
                2'b10:   strb.addrLow  = condFlag;
                default: strb.addrLow  = !condFlag;
              endcase
            end
            SUB_IO: ;
            default: begin
              strb.jump  = 1'b1;
              strb.field = instr[3:0];
            end
          endcase
        end
      endcase
    end
  end

  // At most one action per microinstruction (R3..R11)
  always_comb begin : chk_one_action
    assert_one_action_R11: assert ($onehot0({strb.accLoad, strb.accStore, strb.aluAdd,
      strb.addrLow, strb.addrPage, strb.fetch, strb.funcSet, strb.jump}));
  end
endmodule

// File: rtl/useq_path.sv
module useq_path
  import useq_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData,
  input  logic [ADDR_W-1:0] dataIn,
  input  strobe_t           strb,
  output logic [7:0]        instr,
  output logic [ADDR_W-1:0] upc,
  output logic [REG_W-1:0]  regSel,
  output logic [DISP_W-1:0] displ,
  output logic [FUNC_W-1:0] aluFunc,
  output logic              accLoadEn,
  output logic              accStoreEn,
  output logic              aluAddEn,
  output logic              addrLowWe,
  output logic              addrPageWe,
  output logic              fetchEn
);
  logic [7:0]        store [DEPTH];
  logic [ADDR_W-1:0] upcNext;
  logic              funcPending;
  logic [FUNC_W-1:0] funcHeld;

  always_ff @(posedge clk) begin
    if (loadEn) store[loadAddr] <= loadData;
  end

  assign instr = store[upc];

  always_comb begin
    if (strb.fetch)     upcNext = dataIn;
    else if (strb.jump) upcNext = {upc[ADDR_W-1:4], strb.field};
    else                upcNext = upc + ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upc         <= '0;
      funcPending <= 1'b0;
      funcHeld    <= FUNC_DEFAULT;
    end else begin
      upc <= upcNext;
      if (strb.funcSet) begin
        funcPending <= 1'b1;
        funcHeld    <= strb.field;
      end else if (strb.aluAdd) begin
        funcPending <= 1'b0;
      end
    end
  end

  assign aluFunc    = funcPending ? funcHeld : FUNC_DEFAULT;
  assign regSel     = strb.regSel;
  assign displ      = strb.displ;
  assign accLoadEn  = strb.accLoad;
  assign accStoreEn = strb.accStore;
  assign aluAddEn   = strb.aluAdd;
  assign addrLowWe  = strb.addrLow;
  assign addrPageWe = strb.addrPage;
  assign fetchEn    = strb.fetch;

  assert_fetch_dispatch_R9: assert property (@(posedge clk) disable iff (rst)
    fetchEn |=> upc == $past(dataIn));

  assert_jump_page_R10: assert property (@(posedge clk) disable iff (rst)
    strb.jump |=> (upc[3:0] == $past(strb.field)) && (upc[ADDR_W-1:4] == $past(upc[ADDR_W-1:4])));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!fetchEn && !strb.jump) |=> upc == $past(upc) + ADDR_W'(1));

  assert_func_revert_R6: assert property (@(posedge clk) disable iff (rst)
    aluAddEn |=> aluFunc == FUNC_DEFAULT);

  assert_func_apply_R6: assert property (@(posedge clk) disable iff (rst)
    strb.funcSet |=> aluFunc == $past(strb.field));
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import useq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       loadEn,
  input  logic [7:0] loadAddr,
  input  logic [7:0] loadData,
  input  logic [7:0] dataIn,
  input  logic       condFlag,
  output logic [7:0] upc,
  output logic [1:0] regSel,
  output logic [3:0] displ,
  output logic [3:0] aluFunc,
  output logic       accLoadEn,
  output logic       accStoreEn,
  output logic       aluAddEn,
  output logic       addrLowWe,
  output logic       addrPageWe,
  output logic       fetchEn
);
  strobe_t    strb;
  logic [7:0] instr;

  useq_ctrl u_ctrl (
    .hold     (rst),
    .instr    (instr),
    .condFlag (condFlag),
    .strb     (strb)
  );

  useq_path #(.ADDR_W(8)) u_path (
    .clk        (clk),
    .rst        (rst),
    .loadEn     (loadEn),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .dataIn     (dataIn),
    .strb       (strb),
    .instr      (instr),
    .upc        (upc),
    .regSel     (regSel),
    .displ      (displ),
    .aluFunc    (aluFunc),
    .accLoadEn  (accLoadEn),
    .accStoreEn (accStoreEn),
    .aluAddEn   (aluAddEn),
    .addrLowWe  (addrLowWe),
    .addrPageWe (addrPageWe),
    .fetchEn    (fetchEn)
  );

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (upc == 8'd0) || rst == 1'b0);
endmodule

// File: tb/ucode_sequencer_test.sv
module ucode_sequencer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       loadEn = 1'b0;
  logic [7:0] loadAddr = '0;
  logic [7:0] loadData = '0;
  logic [7:0] dataIn = '0;
  logic       condFlag = 1'b0;
  logic [7:0] upc;
  logic [1:0] regSel;
  logic [3:0] displ;
  logic [3:0] aluFunc;
  logic       accLoadEn, accStoreEn, aluAddEn, addrLowWe, addrPageWe, fetchEn;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ucode_sequencer uut (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // strobe order: accLoad accStore aluAdd addrLow addrPage fetch
  task automatic checkOut(input string req, input logic [7:0] eUpc, input logic [5:0] eStb,
                          input logic [1:0] eReg, input logic [3:0] eDisp, input logic [3:0] eFunc);
    check(req, "upc", upc, eUpc);
    check(req, "strobes", {accLoadEn, accStoreEn, aluAddEn, addrLowWe, addrPageWe, fetchEn}, eStb);
    check(req, "regSel", regSel, eReg);
    check(req, "displ", displ, eDisp);
    check(req, "aluFunc", aluFunc, eFunc);
  endtask

  task automatic put(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    loadEn = 1'b1; loadAddr = a; loadData = d;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic begin_run();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic release_run();
    @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic test_basic_ops();
    begin_run();
    put(8'h00, 8'h26); put(8'h01, 8'h5B); put(8'h02, 8'h83);
    put(8'h03, 8'hE5); put(8'h04, 8'h01);
    check("R1", "reset upc", upc, 0);
    check("R1", "reset strobes", {accLoadEn, accStoreEn, aluAddEn, addrLowWe, addrPageWe, fetchEn}, 0);
    check("R1", "reset func", aluFunc, 0);
    release_run();
    checkOut("R3", 8'h00, 6'b100000, 2'd2, 4'h6, 4'h0);
    step(); checkOut("R4", 8'h01, 6'b010000, 2'd1, 4'hB, 4'h0);
    step(); checkOut("R5", 8'h02, 6'b001000, 2'd0, 4'h3, 4'h0);
    step(); checkOut("R11", 8'h03, 6'b000000, 2'd0, 4'h0, 4'h0);
    step(); checkOut("R3", 8'h04, 6'b100000, 2'd0, 4'h1, 4'h0);
    step(); check("R2", "step upc", upc, 8'h05);
  endtask

  task automatic test_fetch_wrap();
    begin_run();
    put(8'h00, 8'h08); put(8'h40, 8'h09); put(8'hFE, 8'hE0); put(8'hFF, 8'h01);
    release_run();
    dataIn = 8'h40;
    checkOut("R9", 8'h00, 6'b000001, 2'd0, 4'h0, 4'h0);
    step(); dataIn = 8'hFE;
    checkOut("R9", 8'h40, 6'b000001, 2'd0, 4'h1, 4'h0);
    step(); checkOut("R9", 8'hFE, 6'b000000, 2'd0, 4'h0, 4'h0);
    step(); checkOut("R3", 8'hFF, 6'b100000, 2'd0, 4'h1, 4'h0);
    step(); check("R2", "wrap upc", upc, 8'h00);
  endtask

  task automatic test_func_select();
    begin_run();
    put(8'h00, 8'hC5); put(8'h01, 8'h12); put(8'h02, 8'h97); put(8'h03, 8'hA0);
    put(8'h04, 8'hC3); put(8'h05, 8'hC9); put(8'h06, 8'h80);
    release_run();
    checkOut("R6", 8'h00, 6'b000000, 2'd0, 4'h0, 4'h0);
    step(); checkOut("R6", 8'h01, 6'b100000, 2'd1, 4'h2, 4'h5);
    step(); checkOut("R6", 8'h02, 6'b001000, 2'd1, 4'h7, 4'h5);
    step(); checkOut("R6", 8'h03, 6'b001000, 2'd2, 4'h0, 4'h0);
    step(); step();
    step(); checkOut("R6", 8'h06, 6'b001000, 2'd0, 4'h0, 4'h9);
  endtask

  task automatic test_addr_writes(input logic cond);
    begin_run();
    put(8'h00, 8'hD8); put(8'h01, 8'hD5); put(8'h02, 8'hDE); put(8'h03, 8'hD3);
    release_run();
    condFlag = cond;
    checkOut("R7", 8'h00, 6'b000100, 2'd2, 4'h0, 4'h0);
    step(); checkOut("R7", 8'h01, 6'b000010, 2'd1, 4'h0, 4'h0);
    step(); checkOut("R8", 8'h02, {3'b000, cond, 2'b00}, 2'd3, 4'h0, 4'h0);
    step(); checkOut("R8", 8'h03, {3'b000, !cond, 2'b00}, 2'd0, 4'h0, 4'h0);
    condFlag = 1'b0;
  endtask

  task automatic test_jump();
    begin_run();
    put(8'h00, 8'hF7); put(8'h07, 8'h08); put(8'h53, 8'hF2); put(8'h52, 8'hE0);
    release_run();
    dataIn = 8'h53;
    step(); check("R10", "jump low page", upc, 8'h07);
    step(); check("R9", "dispatch", upc, 8'h53);
    step(); check("R10", "jump keeps page", upc, 8'h52);
    step(); check("R11", "io step", upc, 8'h53);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    test_basic_ops();
    test_fetch_wrap();
    test_func_select();
    test_addr_writes(1'b1);
    test_addr_writes(1'b0);
    test_jump();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule